// File: doc/BRIEF.md
# Flash ECC Error Reporting Unit

This unit sits after the ECC check of a flash read datapath and before the register file of the flash controller. Each cycle in which a read finishes, it receives the bank that served the read, the flash word address, whether ECC was applied to that read, whether the read came from the host port or from the controller's own sequencer, the transaction kind (instruction fetch or data), and the correctable and uncorrectable error flags of the check.

From these it decides whether the response beat returned to the requester carries a bus error. An uncorrectable error on an instruction fetch always returns an error. On a data read, a lockable policy bit selects whether the error is returned or silenced, so that software can inspect the raw word. Error logging takes no account of the policy: the error code bits, two saturating counters and the per-bank latest-error addresses are updated for every detected error, and a level interrupt is raised when the masked error code changes.

The register side is modelled by plain strobes and masks. Write-one-to-clear masks act on the counters, the error code and the interrupt state. A write strobe with a data bit drives the policy bit. A write-zero-to-clear strobe drives the configuration enable.

Top module: `ecc_err_report`

## Requirements
- R1: A host-port read with `rd_kind_i`=1 (instruction), `rd_done_i`=1, `rd_ecc_en_i`=1 and `ecc_multi_i`=1 makes `rsp_err_o` 1 on the beat one cycle later, whatever the policy bit.
- R2: Under the same conditions on a data read (`rd_kind_i`=0), `rsp_err_o` is 1 only if `pol_o` was 1 in the cycle of the read; otherwise the error is silenced.
- R3: A read with `rd_host_i`=0 is treated as a data read even when `rd_kind_i`=1.
- R4: `rsp_valid_o` is `rd_done_i` delayed by one cycle. `rsp_err_o` is only ever 1 together with `rsp_valid_o`, for exactly that beat. Error flags are ignored unless `rd_done_i` and `rd_ecc_en_i` are both 1.
- R5: Two counters of `CntW` bits (default 8) reset to 0. `sbe_cnt_o` increments by one for each cycle with a considered correctable error, and `mbe_cnt_o` does the same for uncorrectable errors. Both saturate at all ones (255) and never wrap.
- R6: A nonzero counter clear mask clears the masked bits in that cycle, and an increment in the same cycle is dropped. A mask of all ones therefore yields 0.
- R7: Bank b's field of `sbe_addr_o` or `mbe_addr_o` (bits [b*FullAddrW +: FullAddrW]) loads `{rd_word_addr_i, ByteOffW zeros}` only when a considered error of that class is reported with `rd_bank_i`=b. Otherwise it holds, and it resets to 0.
- R8: `err_code_o` bit positions are 0 flash error, 1 flash alert, 2 protection error, 3 correctable ECC, and 4 uncorrectable ECC. A bit is set by its event and cleared by writing 1 to `err_code_clr_i`. When an event and a clear hit the same bit in the same cycle, the event wins.
- R9: `cfgen_o` resets to 1 and is cleared by `cfgen_wr_i` with `cfgen_wdata_i`=0. Once cleared, it stays 0 until reset. `pol_o` resets to 0 and takes `pol_wdata_i` on `pol_wr_i` only while `cfgen_o` is 1.
- R10: The interrupt state is set one cycle after `err_code_o & irq_mask_i` differs from its value in the previous cycle, or one cycle after `irq_test_i`. It is cleared by `irq_clr_i`, and a set wins over a clear. `irq_o` is the state ANDed with `irq_enable_i`.
- R11: Logging (R5, R7, R8) happens for every considered error, including errors whose response is silenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_done_i | input | 1 | A read completes this cycle |
| rd_ecc_en_i | input | 1 | ECC was applied to this read |
| rd_host_i | input | 1 | Read came from the host port (0: internal sequencer) |
| rd_kind_i | input | 1 | Transaction kind, 1 instruction fetch, 0 data |
| rd_bank_i | input | BankW | Bank that served the read |
| rd_word_addr_i | input | WordAddrW | Flash word address of the read |
| ecc_single_i | input | 1 | Correctable error detected |
| ecc_multi_i | input | 1 | Uncorrectable error detected |
| flash_err_i | input | 1 | Flash operation error event |
| flash_alert_i | input | 1 | Flash alert event |
| prot_err_i | input | 1 | Memory protection error event |
| pol_wr_i | input | 1 | Policy bit write strobe |
| pol_wdata_i | input | 1 | Policy bit write value |
| cfgen_wr_i | input | 1 | Configuration enable write strobe |
| cfgen_wdata_i | input | 1 | Configuration enable write value (0 clears) |
| sbe_cnt_clr_i | input | CntW | Correctable counter clear mask |
| mbe_cnt_clr_i | input | CntW | Uncorrectable counter clear mask |
| err_code_clr_i | input | 5 | Error code clear mask |
| irq_mask_i | input | 5 | Error code interrupt mask |
| irq_enable_i | input | 1 | Interrupt output enable |
| irq_test_i | input | 1 | Interrupt test strobe |
| irq_clr_i | input | 1 | Interrupt state clear strobe |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_err_o | output | 1 | Response beat carries a bus error |
| pol_o | output | 1 | Policy: return uncorrectable errors on data reads |
| cfgen_o | output | 1 | Policy writes permitted |
| err_code_o | output | 5 | Error code bits |
| sbe_cnt_o | output | CntW | Correctable error count |
| mbe_cnt_o | output | CntW | Uncorrectable error count |
| sbe_addr_o | output | NumBanks*FullAddrW | Latest correctable error address per bank |
| mbe_addr_o | output | NumBanks*FullAddrW | Latest uncorrectable error address per bank |
| irq_o | output | 1 | Error interrupt |

## Verification
Every cycle, the bound checker checks the following relations: a response error is never raised without a valid beat, an instruction-fetch uncorrectable error always produces an error beat, and a data error is silenced when the policy is off. It also checks that the counters only step by one or hold and stop at all ones, that a clear mask zeroes its bits, that the lock is sticky and freezes the policy, that an uncorrectable error sets code bit 4, and that an interrupt test reaches the output when enabled. Only the bench's scenarios show the rest. These are the exact address values per bank and class, that silenced errors are still counted and logged, and the saturation after a long run of errors. They also include that clears lose to same-cycle events on the code but win on the counters, and that the interrupt follows changes to the interrupt mask as well as new errors.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

   localparam int unsigned CodeW = 5;

   // bit positions of the error code; the interrupt mask uses the same layout
   localparam int unsigned CodeFlash  = 0;
   localparam int unsigned CodeAlert  = 1;
   localparam int unsigned CodeProt   = 2;
   localparam int unsigned CodeSingle = 3;
   localparam int unsigned CodeMulti  = 4;

   typedef enum logic {
      TxData  = 1'b0,
      TxInstr = 1'b1
   } txn_kind_e;

   typedef struct packed {
      logic multi;
      logic single;
      logic prot;
      logic alert;
      logic flash;
   } err_code_t;

endpackage

// File: rtl/ecc_rsp_policy.sv
module ecc_rsp_policy
   import ecc_err_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      rd_done_i,
   input  logic      rd_ecc_en_i,
   input  logic      rd_host_i,
   input  txn_kind_e rd_kind_i,
   input  logic      ecc_single_i,
   input  logic      ecc_multi_i,
   input  logic      pol_wr_i,
   input  logic      pol_wdata_i,
   input  logic      cfgen_wr_i,
   input  logic      cfgen_wdata_i,
   output logic      single_evt_o,
   output logic      multi_evt_o,
   output logic      rsp_valid_o,
   output logic      rsp_err_o,
   output logic      pol_o,
   output logic      cfgen_o
);

   logic      considered;
   txn_kind_e eff_kind;
   logic      return_err;
   logic      pol_q, cfgen_q;
   logic      rsp_valid_q, rsp_err_q;

   // errors only count when a read finishes with ECC applied
   assign considered   = rd_done_i & rd_ecc_en_i;
   assign single_evt_o = considered & ecc_single_i;
   assign multi_evt_o  = considered & ecc_multi_i;

   // sequencer-issued reads are always data reads
   assign eff_kind   = rd_host_i ? rd_kind_i : TxData;
   assign return_err = multi_evt_o & ((eff_kind == TxInstr) | pol_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfgen_q <= 1'b1;
         pol_q   <= 1'b0;
      end else begin
         if (cfgen_wr_i && !cfgen_wdata_i) begin
            cfgen_q <= 1'b0;
         end
         if (pol_wr_i && cfgen_q) begin
            pol_q <= pol_wdata_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
      end else begin
         rsp_valid_q <= rd_done_i;
         rsp_err_q   <= return_err;
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_err_o   = rsp_err_q;
   assign pol_o       = pol_q;
   assign cfgen_o     = cfgen_q;

endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
   parameter int unsigned Width = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   input  logic [Width-1:0] clr_mask_i,
   output logic [Width-1:0] cnt_o
);

   localparam logic [Width-1:0] MaxVal = {Width{1'b1}};
   localparam logic [Width-1:0] One    = {{(Width-1){1'b0}}, 1'b1};

   logic [Width-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (|clr_mask_i) begin
         // a software clear takes the whole cycle; the increment is dropped
         cnt_d = cnt_q & ~clr_mask_i;
      end else if (inc_i && (cnt_q != MaxVal)) begin
         cnt_d = cnt_q + One;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/ecc_addr_log.sv
module ecc_addr_log #(
   parameter int unsigned NumBanks  = 2,
   parameter int unsigned WordAddrW = 16,
   parameter int unsigned ByteOffW  = 3,
   parameter int unsigned BankW     = 1
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              load_i,
   input  logic [BankW-1:0]                  bank_i,
   input  logic [WordAddrW-1:0]              word_addr_i,
   output logic [NumBanks*(WordAddrW+ByteOffW)-1:0] addr_o
);

   localparam int unsigned FullAddrW = WordAddrW + ByteOffW;

   for (genvar b = 0; b < NumBanks; b++) begin : g_bank
      logic [WordAddrW-1:0] word_q;
      logic                 hit;

      assign hit = load_i && (bank_i == BankW'(b));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            word_q <= '0;
         end else if (hit) begin
            word_q <= word_addr_i;
         end
      end

      // the report is a byte address aligned to the full flash word
      assign addr_o[b*FullAddrW +: FullAddrW] = {word_q, {ByteOffW{1'b0}}};
   end

endmodule

// File: rtl/ecc_err_irq.sv
module ecc_err_irq
   import ecc_err_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CodeW-1:0] set_i,
   input  logic [CodeW-1:0] clr_i,
   input  logic [CodeW-1:0] mask_i,
   input  logic             enable_i,
   input  logic             test_i,
   input  logic             state_clr_i,
   output logic [CodeW-1:0] code_o,
   output logic             irq_o
);

   err_code_t        code_q;
   logic [CodeW-1:0] masked, masked_q;
   logic             change_evt;
   logic             state_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= '0;
      end else begin
         // hardware set has priority over the software clear
         code_q <= (code_q & ~clr_i) | set_i;
      end
   end

   assign masked = code_q & mask_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         masked_q <= '0;
      end else begin
         masked_q <= masked;
      end
   end

   assign change_evt = (masked != masked_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= 1'b0;
      end else begin
         state_q <= (state_q & ~state_clr_i) | change_evt | test_i;
      end
   end

   assign code_o = code_q;
   assign irq_o  = state_q & enable_i;

endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
   import ecc_err_pkg::*;
#(
   parameter int unsigned NumBanks  = 2,
   parameter int unsigned WordAddrW = 16,
   parameter int unsigned BusBytes  = 8,
   parameter int unsigned CntW      = 8,
   localparam int unsigned BankW     = (NumBanks > 1) ? $clog2(NumBanks) : 1,
   localparam int unsigned ByteOffW  = $clog2(BusBytes),
   localparam int unsigned FullAddrW = WordAddrW + ByteOffW
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          rd_done_i,
   input  logic                          rd_ecc_en_i,
   input  logic                          rd_host_i,
   input  logic                          rd_kind_i,
   input  logic [BankW-1:0]              rd_bank_i,
   input  logic [WordAddrW-1:0]          rd_word_addr_i,
   input  logic                          ecc_single_i,
   input  logic                          ecc_multi_i,
   input  logic                          flash_err_i,
   input  logic                          flash_alert_i,
   input  logic                          prot_err_i,
   input  logic                          pol_wr_i,
   input  logic                          pol_wdata_i,
   input  logic                          cfgen_wr_i,
   input  logic                          cfgen_wdata_i,
   input  logic [CntW-1:0]               sbe_cnt_clr_i,
   input  logic [CntW-1:0]               mbe_cnt_clr_i,
   input  logic [4:0]                    err_code_clr_i,
   input  logic [4:0]                    irq_mask_i,
   input  logic                          irq_enable_i,
   input  logic                          irq_test_i,
   input  logic                          irq_clr_i,
   output logic                          rsp_valid_o,
   output logic                          rsp_err_o,
   output logic                          pol_o,
   output logic                          cfgen_o,
   output logic [4:0]                    err_code_o,
   output logic [CntW-1:0]               sbe_cnt_o,
   output logic [CntW-1:0]               mbe_cnt_o,
   output logic [NumBanks*FullAddrW-1:0] sbe_addr_o,
   output logic [NumBanks*FullAddrW-1:0] mbe_addr_o,
   output logic                          irq_o
);

   initial begin
      if (NumBanks < 1)  $fatal(1, "NumBanks must be at least 1");
      if (BusBytes < 2)  $fatal(1, "BusBytes must be at least 2");
      if (CntW < 2)      $fatal(1, "CntW must be at least 2");
      if (WordAddrW < 1) $fatal(1, "WordAddrW must be at least 1");
   end

   logic      single_evt, multi_evt;
   txn_kind_e kind;
   err_code_t code_set;

   assign kind = txn_kind_e'(rd_kind_i);

   ecc_rsp_policy u_policy (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .rd_done_i     (rd_done_i),
      .rd_ecc_en_i   (rd_ecc_en_i),
      .rd_host_i     (rd_host_i),
      .rd_kind_i     (kind),
      .ecc_single_i  (ecc_single_i),
      .ecc_multi_i   (ecc_multi_i),
      .pol_wr_i      (pol_wr_i),
      .pol_wdata_i   (pol_wdata_i),
      .cfgen_wr_i    (cfgen_wr_i),
      .cfgen_wdata_i (cfgen_wdata_i),
      .single_evt_o  (single_evt),
      .multi_evt_o   (multi_evt),
      .rsp_valid_o   (rsp_valid_o),
      .rsp_err_o     (rsp_err_o),
      .pol_o         (pol_o),
      .cfgen_o       (cfgen_o)
   );

   ecc_sat_counter #(.Width(CntW)) u_sbe_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (single_evt),
      .clr_mask_i (sbe_cnt_clr_i),
      .cnt_o      (sbe_cnt_o)
   );

   ecc_sat_counter #(.Width(CntW)) u_mbe_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (multi_evt),
      .clr_mask_i (mbe_cnt_clr_i),
      .cnt_o      (mbe_cnt_o)
   );

   ecc_addr_log #(
      .NumBanks  (NumBanks),
      .WordAddrW (WordAddrW),
      .ByteOffW  (ByteOffW),
      .BankW     (BankW)
   ) u_sbe_addr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (single_evt),
      .bank_i      (rd_bank_i),
      .word_addr_i (rd_word_addr_i),
      .addr_o      (sbe_addr_o)
   );

   ecc_addr_log #(
      .NumBanks  (NumBanks),
      .WordAddrW (WordAddrW),
      .ByteOffW  (ByteOffW),
      .BankW     (BankW)
   ) u_mbe_addr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (multi_evt),
      .bank_i      (rd_bank_i),
      .word_addr_i (rd_word_addr_i),
      .addr_o      (mbe_addr_o)
   );

   assign code_set.flash  = flash_err_i;
   assign code_set.alert  = flash_alert_i;
   assign code_set.prot   = prot_err_i;
   assign code_set.single = single_evt;
   assign code_set.multi  = multi_evt;

   ecc_err_irq u_irq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (code_set),
      .clr_i       (err_code_clr_i),
      .mask_i      (irq_mask_i),
      .enable_i    (irq_enable_i),
      .test_i      (irq_test_i),
      .state_clr_i (irq_clr_i),
      .code_o      (err_code_o),
      .irq_o       (irq_o)
   );

endmodule

// File: rtl/ecc_err_report_chk.sv
module ecc_err_report_chk #(
   parameter int unsigned CntW = 8
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            rd_done_i,
   input logic            rd_ecc_en_i,
   input logic            rd_host_i,
   input logic            rd_kind_i,
   input logic            ecc_multi_i,
   input logic            rsp_valid_o,
   input logic            rsp_err_o,
   input logic            pol_o,
   input logic            cfgen_o,
   input logic [4:0]      err_code_o,
   input logic [CntW-1:0] sbe_cnt_clr_i,
   input logic [CntW-1:0] sbe_cnt_o,
   input logic [CntW-1:0] mbe_cnt_clr_i,
   input logic [CntW-1:0] mbe_cnt_o,
   input logic            irq_test_i,
   input logic            irq_enable_i,
   input logic            irq_o
);

   localparam logic [CntW-1:0] Top = {CntW{1'b1}};
   localparam logic [CntW-1:0] One = {{(CntW-1){1'b0}}, 1'b1};

   logic hard_err;
   assign hard_err = rd_done_i && rd_ecc_en_i && ecc_multi_i;

   p_err_needs_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_err_o |-> rsp_valid_o);

   p_instr_always_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hard_err && rd_host_i && rd_kind_i) |=> rsp_err_o);

   p_data_silenced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hard_err && !(rd_host_i && rd_kind_i) && !pol_o) |=> !rsp_err_o);

   p_code_multi_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hard_err |=> err_code_o[4]);

   p_sbe_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sbe_cnt_clr_i == '0) |=> (sbe_cnt_o == $past(sbe_cnt_o)) ||
                                 (sbe_cnt_o == $past(sbe_cnt_o) + One));

   p_mbe_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mbe_cnt_clr_i == '0) |=> (mbe_cnt_o == $past(mbe_cnt_o)) ||
                                 (mbe_cnt_o == $past(mbe_cnt_o) + One));

   p_sbe_saturate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sbe_cnt_o == Top && sbe_cnt_clr_i == '0) |=> (sbe_cnt_o == Top));

   p_sbe_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sbe_cnt_clr_i != '0) |=> ((sbe_cnt_o & $past(sbe_cnt_clr_i)) == '0));

   p_mbe_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mbe_cnt_clr_i != '0) |=> ((mbe_cnt_o & $past(mbe_cnt_clr_i)) == '0));

   p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfgen_o |=> !cfgen_o);

   p_lock_freezes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfgen_o |=> $stable(pol_o));

   p_test_reaches_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_test_i |=> (!irq_enable_i || irq_o));

endmodule

bind ecc_err_report ecc_err_report_chk #(.CntW(CntW)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .rd_done_i     (rd_done_i),
   .rd_ecc_en_i   (rd_ecc_en_i),
   .rd_host_i     (rd_host_i),
   .rd_kind_i     (rd_kind_i),
   .ecc_multi_i   (ecc_multi_i),
   .rsp_valid_o   (rsp_valid_o),
   .rsp_err_o     (rsp_err_o),
   .pol_o         (pol_o),
   .cfgen_o       (cfgen_o),
   .err_code_o    (err_code_o),
   .sbe_cnt_clr_i (sbe_cnt_clr_i),
   .sbe_cnt_o     (sbe_cnt_o),
   .mbe_cnt_clr_i (mbe_cnt_clr_i),
   .mbe_cnt_o     (mbe_cnt_o),
   .irq_test_i    (irq_test_i),
   .irq_enable_i  (irq_enable_i),
   .irq_o         (irq_o)
);

// File: tb/tb_ecc_err_report.sv
`timescale 1ns/1ps
module tb_ecc_err_report;

   localparam int NB    = 2;
   localparam int WAW   = 16;
   localparam int BOFF  = 3;
   localparam int FAW   = WAW + BOFF;
   localparam int CW    = 8;
   localparam int LIMIT = 200000;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   always #2.5 clk = ~clk;

   logic           rd_done, rd_ecc_en, rd_host, rd_kind;
   logic [0:0]     rd_bank;
   logic [WAW-1:0] rd_addr;
   logic           e_single, e_multi, f_err, f_alert, p_err;
   logic           pol_wr, pol_wd, cfg_wr, cfg_wd;
   logic [CW-1:0]  s_clr, m_clr;
   logic [4:0]     c_clr, i_mask;
   logic           i_en, i_test, i_clr;

   logic              rsp_valid, rsp_err, pol, cfgen, irq;
   logic [4:0]        code;
   logic [CW-1:0]     scnt, mcnt;
   logic [NB*FAW-1:0] saddr, maddr;

   ecc_err_report dut (
      .clk_i(clk), .rst_ni(rst_ni),
      .rd_done_i(rd_done), .rd_ecc_en_i(rd_ecc_en), .rd_host_i(rd_host),
      .rd_kind_i(rd_kind), .rd_bank_i(rd_bank), .rd_word_addr_i(rd_addr),
      .ecc_single_i(e_single), .ecc_multi_i(e_multi),
      .flash_err_i(f_err), .flash_alert_i(f_alert), .prot_err_i(p_err),
      .pol_wr_i(pol_wr), .pol_wdata_i(pol_wd), .cfgen_wr_i(cfg_wr), .cfgen_wdata_i(cfg_wd),
      .sbe_cnt_clr_i(s_clr), .mbe_cnt_clr_i(m_clr), .err_code_clr_i(c_clr),
      .irq_mask_i(i_mask), .irq_enable_i(i_en), .irq_test_i(i_test), .irq_clr_i(i_clr),
      .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .pol_o(pol), .cfgen_o(cfgen),
      .err_code_o(code), .sbe_cnt_o(scnt), .mbe_cnt_o(mcnt),
      .sbe_addr_o(saddr), .mbe_addr_o(maddr), .irq_o(irq)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_rv, m_re, m_pol, m_cfgen, m_state;
   int          m_sc, m_mc;
   bit [4:0]    m_code, m_prev_masked;
   int          m_saddr [NB];
   int          m_maddr [NB];
   bit          model_live = 0;

   function automatic int after_clear(int v, logic [CW-1:0] m);
      int r = v;
      for (int i = 0; i < CW; i++) if (m[i]) r = r & ~(1 << i);
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_ni) begin
         m_rv = 0; m_re = 0; m_pol = 0; m_cfgen = 1; m_state = 0;
         m_sc = 0; m_mc = 0; m_code = 0; m_prev_masked = 0;
         for (int b = 0; b < NB; b++) begin m_saddr[b] = 0; m_maddr[b] = 0; end
      end else begin
         bit seen_s, seen_m, fetch, changed;
         bit [4:0] mk, raised;
         seen_s = rd_done && rd_ecc_en && e_single;
         seen_m = rd_done && rd_ecc_en && e_multi;
         fetch  = rd_host && rd_kind;
         mk      = m_code & i_mask;
         changed = (mk != m_prev_masked);
         m_prev_masked = mk;
         m_rv = rd_done;
         m_re = seen_m && (fetch || m_pol);
         if (pol_wr && m_cfgen) m_pol = pol_wd;
         if (cfg_wr && !cfg_wd) m_cfgen = 0;
         if (s_clr != 0) m_sc = after_clear(m_sc, s_clr);
         else if (seen_s && m_sc < 255) m_sc++;
         if (m_clr != 0) m_mc = after_clear(m_mc, m_clr);
         else if (seen_m && m_mc < 255) m_mc++;
         if (seen_s) m_saddr[rd_bank] = int'(rd_addr) << BOFF;
         if (seen_m) m_maddr[rd_bank] = int'(rd_addr) << BOFF;
         raised = {seen_m, seen_s, p_err, f_alert, f_err};
         m_code = (m_code & ~c_clr) | raised;
         m_state = (m_state && !i_clr) || changed || i_test;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (model_live) begin
         check("R4 rsp_valid", 64'(rsp_valid), 64'(m_rv));
         check("R1 R2 R3 rsp_err", 64'(rsp_err), 64'(m_re));
         check("R9 pol", 64'(pol), 64'(m_pol));
         check("R9 cfgen", 64'(cfgen), 64'(m_cfgen));
         check("R8 R11 err_code", 64'(code), 64'(m_code));
         check("R5 R6 R11 sbe_cnt", 64'(scnt), 64'(m_sc));
         check("R5 R6 R11 mbe_cnt", 64'(mcnt), 64'(m_mc));
         for (int b = 0; b < NB; b++) begin
            check("R7 R11 sbe_addr", 64'(saddr[b*FAW +: FAW]), 64'(m_saddr[b]));
            check("R7 R11 mbe_addr", 64'(maddr[b*FAW +: FAW]), 64'(m_maddr[b]));
         end
         check("R10 irq", 64'(irq), 64'(m_state && i_en));
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle();
      rd_done = 0; rd_ecc_en = 0; rd_host = 0; rd_kind = 0; rd_bank = 0; rd_addr = 0;
      e_single = 0; e_multi = 0; f_err = 0; f_alert = 0; p_err = 0;
      pol_wr = 0; pol_wd = 0; cfg_wr = 0; cfg_wd = 1;
      s_clr = 0; m_clr = 0; c_clr = 0; i_test = 0; i_clr = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      idle();
   endtask

   task automatic rd(bit bank, int addr, bit ecc, bit host, bit kind, bit s, bit m);
      rd_done = 1; rd_bank = bank; rd_addr = WAW'(addr); rd_ecc_en = ecc;
      rd_host = host; rd_kind = kind; e_single = s; e_multi = m;
   endtask

   initial begin
      #(LIMIT * 5);
      errors++;
      checks++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle();
      i_mask = 0; i_en = 0;
      repeat (3) @(negedge clk);
      rst_ni = 1;
      @(negedge clk);
      model_live = 1;
      // reset state
      check("R9 reset cfgen", 64'(cfgen), 64'd1);
      check("R5 reset count", 64'(scnt), 64'd0);
      check("R8 reset code", 64'(code), 64'd0);

      // R1: instruction fetch, policy off
      rd(0, 16'h0005, 1, 1, 1, 0, 1); tick();
      check("R1 instr error returned", 64'(rsp_err), 64'd1);
      check("R7 multi addr bank0", 64'(maddr[0 +: FAW]), 64'h28);
      // R2: data read silenced, still logged (R11)
      rd(1, 16'h0102, 1, 1, 0, 0, 1); tick();
      check("R2 data error silenced", 64'(rsp_err), 64'd0);
      check("R11 silenced still counted", 64'(mcnt), 64'd2);
      // R3: internal read marked instruction behaves as data
      rd(0, 16'h0003, 1, 0, 1, 0, 1); tick();
      check("R3 internal read silenced", 64'(rsp_err), 64'd0);
      // enable policy, data error now returned
      pol_wr = 1; pol_wd = 1; tick();
      rd(1, 16'h0044, 1, 1, 0, 0, 1); tick();
      check("R2 data error returned", 64'(rsp_err), 64'd1);
      tick();
      check("R4 single beat", 64'(rsp_err), 64'd0);
      // R4: ECC off or no done means ignored
      rd(0, 16'h0777, 0, 1, 1, 1, 1); tick();
      check("R4 ecc off ignored", 64'(mcnt), 64'd4);
      rd_ecc_en = 1; e_multi = 1; rd_host = 1; rd_kind = 1; tick();
      check("R4 no done ignored", 64'(rsp_err), 64'd0);
      // R9: lock, then try to clear policy
      cfg_wr = 1; cfg_wd = 0; tick();
      pol_wr = 1; pol_wd = 0; tick();
      check("R9 locked policy kept", 64'(pol), 64'd1);
      cfg_wr = 1; cfg_wd = 1; tick();
      check("R9 lock sticky", 64'(cfgen), 64'd0);

      // R5: saturation of correctable count, varied banks and addresses
      for (int i = 0; i < 260; i++) begin
         rd(1'(i), i * 7, 1, i % 3 != 0, 1'(i >> 1), 1, 0); tick();
      end
      check("R5 saturated", 64'(scnt), 64'd255);
      // R6: clear in the same cycle as an error, clear wins
      rd(0, 16'h0011, 1, 1, 0, 1, 0); s_clr = 8'hFF; tick();
      check("R6 clear wins", 64'(scnt), 64'd0);
      rd(0, 16'h0012, 1, 1, 0, 1, 0); tick();
      rd(0, 16'h0013, 1, 1, 0, 1, 0); tick();
      rd(0, 16'h0014, 1, 1, 0, 1, 0); tick();
      s_clr = 8'h01; tick();
      check("R6 partial clear", 64'(scnt), 64'd2);

      // R8: other sources and clear vs set
      f_err = 1; p_err = 1; tick();
      c_clr = 5'b00101; f_err = 1; tick();
      check("R8 set beats clear", 64'(code[0]), 64'd1);
      check("R8 clear bit2", 64'(code[2]), 64'd0);
      f_alert = 1; tick();
      c_clr = 5'b11111; tick();
      check("R8 all cleared", 64'(code), 64'd0);

      // R10: mask, change event, test, clear
      i_en = 1; i_mask = 5'b10000; tick(); tick();
      i_clr = 1; tick();
      rd(1, 16'h0ABC, 1, 1, 1, 0, 1); tick();
      tick();
      check("R10 irq on masked change", 64'(irq), 64'd1);
      i_clr = 1; tick();
      check("R10 irq cleared", 64'(irq), 64'd0);
      i_test = 1; tick();
      check("R10 test raises irq", 64'(irq), 64'd1);
      i_en = 0; tick();
      check("R10 enable gates", 64'(irq), 64'd0);
      i_en = 1; i_clr = 1; i_mask = 5'b01000; tick();
      tick(); tick();
      i_clr = 1; flash_pulse();
      repeat (4) tick();

      model_live = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic flash_pulse();
      f_err = 1; tick();
   endtask

endmodule